// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps one interrupt-pending flag for each timer in a small bank of general-purpose timers and makes that state reachable through a word-addressed register port. A timer reports expiry with a single-cycle pulse, and the pulse latches that timer's flag. Software has two ways to drop a flag. It can write any value to the clear address that belongs to that timer. It can also write a zero into the flag's bit of the shared status word.

The status word also holds a mask bit for each timer. The interrupt line is high while at least one flag is pending with its mask bit set. The current count of each timer comes in on an input bus, and a read-only word returns it. All reads are registered, so read data appears one cycle after the request.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset every flag and every mask bit is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: An expiry pulse on `tmr_expire[i]` sets flag i at the next clock edge. The flag then stays set until a clear reaches it.
- R3: A write to byte address 0x30+4*i clears flag i whatever data is written. The clear addresses for timers 1, 2 and 3 are 0x34, 0x38 and 0x3C. Other flags are left alone.
- R4: A write to the status word (byte address 0x00) clears flag i when data bit i is 0. When data bit i is 1, flag i keeps its value.
- R5: If an expiry pulse and any clear of the same flag fall in the same cycle, the flag ends up set.
- R6: The mask bit of timer i sits in status bit 8+i. A status write loads it, and a status read returns it. Status bits [3:0] read back the flags, and all other status bits read 0.
- R7: `irq` is 1 exactly when some flag i is set and mask bit i is set. It follows the registered state with no extra delay.
- R8: A read of byte address 0x10+4*i returns the 32-bit count of timer i, taken from `tmr_count[32*i +: 32]` at the read cycle. Writes to these addresses change no state.
- R9: Reads return 0 from the clear addresses, from unmapped addresses and from any address whose two low bits are not 00. A misaligned write has no effect.
- R10: Read data appears on `bus_rdata` one cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tmr_expire | input | 4 | One-cycle expiry pulse per timer |
| tmr_count | input | 128 | Current count of each timer, 32 bits per timer |
| irq | output | 1 | Combined masked interrupt |

## Verification
A flag stuck or lost inside the bank shows up on `irq` in the cycle after the event, as long as that timer's mask bit is set. A status read brings the same fault out one cycle after the request. A wrong mask bit shows at the next status read, and it also shows as `irq` failing to follow a pending flag. A decoding fault that clears the wrong timer, or that fails to clear a timer, appears on the first status read after the clear.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int STAT_WIDX = 0;
    localparam int CNT_WIDX  = 4;
    localparam int CLR_WIDX  = 12;
    localparam int EN_LSB    = 8;
endpackage

// File: rtl/tic_addr_dec.sv
module tic_addr_dec #(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 8
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              stat_wr,
    output logic [NUM_TMR-1:0] clr_hit,
    output logic              rd_req,
    output logic              rd_ok,
    output logic [ADDR_W-3:0] widx
);
    import tic_pkg::*;
    logic aligned;

    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        widx    = bus_addr[ADDR_W-1:2];
        stat_wr = bus_sel && bus_we && aligned && (widx == (ADDR_W-2)'(STAT_WIDX));
        rd_req  = bus_sel && !bus_we;
        rd_ok   = aligned;
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_clr
        assign clr_hit[i] = bus_sel && bus_we && aligned &&
                            (widx == (ADDR_W-2)'(CLR_WIDX + i));
    end
endmodule

// File: rtl/tic_flag_bank.sv
module tic_flag_bank #(
    parameter int NUM_TMR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] expire,
    input  logic [NUM_TMR-1:0] clr_hit,
    input  logic               stat_wr,
    input  logic [NUM_TMR-1:0] wr_flag_bits,
    input  logic [NUM_TMR-1:0] wr_en_bits,
    output logic [NUM_TMR-1:0] flags,
    output logic [NUM_TMR-1:0] en
);
    typedef struct packed {
        logic [NUM_TMR-1:0] flag;
        logic [NUM_TMR-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (clr_hit[i] || (stat_wr && !wr_flag_bits[i]))
                st_d.flag[i] = 1'b0;
            if (expire[i])
                st_d.flag[i] = 1'b1;
        end
        if (stat_wr)
            st_d.en = wr_en_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flag;
    assign en    = st_q.en;
endmodule

// File: rtl/tic_read_mux.sv
module tic_read_mux #(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_req,
    input  logic                       rd_ok,
    input  logic [ADDR_W-3:0]          widx,
    input  logic [NUM_TMR-1:0]         flags,
    input  logic [NUM_TMR-1:0]         en,
    input  logic [NUM_TMR*CNT_W-1:0]   count,
    output logic [DATA_W-1:0]          rdata
);
    import tic_pkg::*;
    logic [DATA_W-1:0] rdata_d, rdata_q, word;

    always_comb begin
        word = '0;
        if (rd_ok) begin
            if (widx == (ADDR_W-2)'(STAT_WIDX)) begin
                word[NUM_TMR-1:0]       = flags;
                word[EN_LSB +: NUM_TMR] = en;
            end
            for (int i = 0; i < NUM_TMR; i++) begin
                if (widx == (ADDR_W-2)'(CNT_WIDX + i))
                    word = DATA_W'(count[i*CNT_W +: CNT_W]);
            end
        end
        rdata_d = rd_req ? word : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_TMR-1:0]       tmr_expire,
    input  logic [NUM_TMR*CNT_W-1:0] tmr_count,
    output logic                     irq
);
    import tic_pkg::*;

    logic               stat_wr, rd_req, rd_ok;
    logic [NUM_TMR-1:0] clr_hit, flags_w, en_w;
    logic [ADDR_W-3:0]  widx;

    tic_addr_dec #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_dec (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .stat_wr (stat_wr),
        .clr_hit (clr_hit),
        .rd_req  (rd_req),
        .rd_ok   (rd_ok),
        .widx    (widx)
    );

    tic_flag_bank #(.NUM_TMR(NUM_TMR)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (tmr_expire),
        .clr_hit     (clr_hit),
        .stat_wr     (stat_wr),
        .wr_flag_bits(bus_wdata[NUM_TMR-1:0]),
        .wr_en_bits  (bus_wdata[EN_LSB +: NUM_TMR]),
        .flags       (flags_w),
        .en          (en_w)
    );

    tic_read_mux #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_req(rd_req),
        .rd_ok (rd_ok),
        .widx  (widx),
        .flags (flags_w),
        .en    (en_w),
        .count (tmr_count),
        .rdata (bus_rdata)
    );

    assign irq = |(flags_w & en_w);
endmodule

// File: rtl/tic_checker.sv
module tic_checker #(
    parameter int NUM_TMR = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_TMR-1:0] tmr_expire,
    input logic [NUM_TMR-1:0] flags_w,
    input logic [NUM_TMR-1:0] en_w
);
    import tic_pkg::*;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_expire[i] |=> flags_w[i]);
        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_we && bus_addr == ADDR_W'(4*(CLR_WIDX + i)) && !tmr_expire[i])
            |=> !flags_w[i]);
        assert_keep_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_we && bus_addr == ADDR_W'(0) && bus_wdata[i] && flags_w[i])
            |=> flags_w[i]);
        assert_rise_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_w[i]) |-> $past(tmr_expire[i]));
    end

    assert_en_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(0))
        |=> en_w == $past(bus_wdata[EN_LSB +: NUM_TMR]));

    assert_clr_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr >= ADDR_W'(4*CLR_WIDX)) |=> bus_rdata == '0);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> $stable(bus_rdata));
endmodule

bind tmr_irq_ctrl tic_checker #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tmr_expire(tmr_expire),
    .flags_w   (flags_w),
    .en_w      (en_w)
);

// File: tb/tmr_irq_ctrl_bench.sv
module tmr_irq_ctrl_bench;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] tmr_expire = '0;
    logic [127:0] tmr_count = '0;
    logic         irq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [N-1:0] m_flag = '0, m_en = '0;

    always #5 clk = ~clk;

    tmr_irq_ctrl u_tmr_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_expire(tmr_expire), .tmr_count(tmr_count), .irq(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a, logic [127:0] cnt);
        logic [31:0] w = '0;
        if (a == 8'h00) begin
            w[N-1:0] = m_flag;
            w[8 +: N] = m_en;
        end else if (a >= 8'h10 && a <= 8'h1C && a[1:0] == 2'b00)
            w = cnt[(a - 8'h10) * 8 +: 32];
        return w;
    endfunction

    // one bus cycle; starts and ends at a falling edge
    task automatic step(logic sel, logic we, logic [7:0] a, logic [31:0] d,
                        logic [N-1:0] ex, string tag);
        logic [31:0] er;
        logic [N-1:0] nf;
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d; tmr_expire = ex;
        tmr_count = {$urandom, $urandom, $urandom, $urandom};
        er = exp_read(a, tmr_count);
        nf = m_flag;
        for (int i = 0; i < N; i++) begin
            if (sel && we && a == 8'h30 + 8'(4*i)) nf[i] = 1'b0;
            if (sel && we && a == 8'h00 && !d[i]) nf[i] = 1'b0;
            if (ex[i]) nf[i] = 1'b1;
        end
        @(posedge clk);
        #1;
        m_flag = nf;
        if (sel && we && a == 8'h00) m_en = d[8 +: N];
        bus_sel = 1'b0; tmr_expire = '0;
        @(negedge clk);
        check("R7 irq", {31'd0, irq}, {31'd0, |(m_flag & m_en)});
        if (sel && !we) check(tag, bus_rdata, er);
    endtask

    task automatic rd(logic [7:0] a, string tag);
        step(1'b1, 1'b0, a, 32'h0, '0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h00, "R1 status");

        step(1'b1, 1'b1, 8'h00, 32'h0000_0F00, '0, "R6");
        rd(8'h00, "R6 mask readback");
        step(1'b0, 1'b0, 8'h00, 32'h0, 4'b1010, "R2");
        rd(8'h00, "R2 flags set");
        step(1'b1, 1'b1, 8'h38, 32'h0, '0, "R3");
        rd(8'h00, "R3 clear timer 2 only");
        step(1'b1, 1'b1, 8'h34, 32'hFFFF_FFFF, '0, "R3");
        rd(8'h00, "R3 clear timer 1");
        step(1'b0, 1'b0, 8'h00, 32'h0, 4'b1111, "R2");
        step(1'b1, 1'b1, 8'h00, 32'h0000_0F05, '0, "R4");
        rd(8'h00, "R4 write zero clears, one keeps");
        step(1'b1, 1'b1, 8'h30, 32'h0, 4'b0001, "R5");
        rd(8'h00, "R5 set wins over address clear");
        step(1'b1, 1'b1, 8'h00, 32'h0000_0F00, 4'b0100, "R5");
        rd(8'h00, "R5 set wins over status clear");
        step(1'b1, 1'b1, 8'h00, 32'h0000_000F, '0, "R7");
        rd(8'h00, "R7 masked flags keep irq low");
        step(1'b1, 1'b1, 8'h14, 32'hDEAD_BEEF, '0, "R8");
        rd(8'h00, "R8 count write no effect");
        for (int i = 0; i < N; i++) rd(8'h10 + 8'(4*i), "R8 count read");
        rd(8'h3C, "R9 clear addr reads zero");
        rd(8'h11, "R9 misaligned reads zero");
        rd(8'h24, "R9 unmapped reads zero");
        step(1'b1, 1'b1, 8'h01, 32'h0, '0, "R9");
        rd(8'h00, "R9 misaligned write ignored");
        step(1'b0, 1'b0, 8'h00, 32'h0, '0, "R10");
        check("R10 rdata holds", bus_rdata, exp_read(8'h00, tmr_count));

        void'($urandom(32'h5eed));
        for (int k = 0; k < 600; k++) begin
            int op = $urandom_range(0, 5);
            logic [N-1:0] ex = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            logic [7:0] a;
            case (op)
                0: step(1'b1, 1'b1, 8'h00, $urandom, ex, "R4");
                1: step(1'b1, 1'b1, 8'h30 + 8'(4*$urandom_range(0, 3)), $urandom, ex, "R3");
                2: rd(8'h00, "R6 random status");
                3: begin
                    a = 8'h10 + 8'(4*$urandom_range(0, 3));
                    rd(a, "R8 random count");
                end
                4: begin
                    a = 8'($urandom);
                    rd(a, "R9 random address");
                end
                default: step(1'b0, 1'b0, 8'h00, 32'h0, ex, "R2");
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule